// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

An eight-stage register built from edge-triggered D flip-flops. Each stage either takes its own bit from a parallel bus or takes the value of the stage before it, and stage 1 takes a serial input bit. One select input chooses between the two entries. With the select low, every rising clock edge shifts the register by one stage. With the select high, the register loads the parallel bus.

A build-time parameter sets when the parallel load takes effect. With the clocked setting, the word is captured on the rising clock edge. With the level setting, the stages take the bus as soon as the select is high and keep following it for as long as the select stays high, whatever the clock does. Serial shifting is clocked with either setting.

The last three stages are brought out. The final stage can feed the serial input of a further instance, and several instances that share clock, select and bus then act as one longer register. There is no reset: a known value reaches the register only through a parallel load.

Top module: `plso_shreg`

## Requirements
- R1: The register has 8 stages. Parallel bit `par_in[k-1]` belongs to stage k. `tap_out[0]`, `tap_out[1]` and `tap_out[2]` show stages 6, 7 and 8.
- R2: With `ld_sel` low, each rising edge of `clk` moves stage k-1 into stage k and puts `ser_in` into stage 1. This holds with both settings of `LOAD_ASYNC`.
- R3: With `LOAD_ASYNC`=0, a rising edge with `ld_sel` high loads `par_in` into all stages at once.
- R4: With `LOAD_ASYNC`=1, while `ld_sel` is high the stages take `par_in` without a clock edge and follow any change of it.
- R5: With `LOAD_ASYNC`=1, a rising clock edge while `ld_sel` is high leaves the stages equal to `par_in`.
- R6: A falling clock edge, or a clock held steady, leaves every stage unchanged when no level load is active.
- R7: With `LOAD_ASYNC`=1, after `ld_sel` returns low, the next rising edge shifts starting from the last loaded word.
- R8: With `LOAD_ASYNC`=0, changes of `par_in` between edges do not reach the stages before the next rising edge, even with `ld_sel` high.
- R9: When `tap_out[2]` of one instance drives `ser_in` of a second instance, and both share the clock, select and bus, the pair shifts as one 16-stage register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and clocked-load clock, rising edge active |
| ser_in | input | 1 | Serial bit entering stage 1 |
| ld_sel | input | 1 | 1 selects parallel load, 0 selects serial shift |
| par_in | input | 8 | Parallel word, bit k-1 for stage k |
| tap_out | output | 3 | Stages 6, 7, 8 on bits 0, 1, 2 |

## Verification
The bench builds three instances at the default length of eight stages. It runs two with `LOAD_ASYNC`=0, one feeding the other, and one with `LOAD_ASYNC`=1, all from the same stimulus. Comparing the clocked and level-load instances cycle by cycle shows where they must agree (shifting) and where they must not (a load between edges). The chained pair brings the cascade behaviour within reach. The level-load build also allows a select pulse that opens and closes between two clock edges, which shows that the shift after release starts from the word seen last.

// File: rtl/plso_pkg.sv
package plso_pkg;

   // index of the first stage that is brought out
   function automatic int first_tap(input int stages, input int taps);
      return stages - taps;
   endfunction

endpackage

// File: rtl/plso_cell.sv
module plso_cell #(
   parameter int LOAD_ASYNC = 0
) (
   input  logic clk,
   input  logic ld_sel,
   input  logic ser_bit,
   input  logic par_bit,
   output logic q
);

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   generate
      if (LOAD_ASYNC != 0) begin : g_lvl
         logic set_n, clr_n;
         assign set_n = ld_sel &  par_bit;
         assign clr_n = ld_sel & ~par_bit;

         always_ff @(posedge clk or posedge set_n or posedge clr_n) begin
            if (clr_n)      q <= 1'b0;
            else if (set_n) q <= 1'b1;
            else            q <= ser_bit;
         end

         // R5
         lvl_hold_chk: assert property (@(posedge clk) disable iff (!armed)
            (ld_sel && $past(ld_sel)) |-> (q == par_bit));
      end else begin : g_clk
         always_ff @(posedge clk) begin
            q <= ld_sel ? par_bit : ser_bit;
         end

         // R3
         clk_load_chk: assert property (@(posedge clk) disable iff (!armed)
            ld_sel |=> (q == $past(par_bit)));

         // R2
         clk_shift_chk: assert property (@(posedge clk) disable iff (!armed)
            !ld_sel |=> (q == $past(ser_bit)));
      end
   endgenerate

endmodule

// File: rtl/plso_tap_buf.sv
module plso_tap_buf
   import plso_pkg::*;
#(
   parameter int STAGES = 8,
   parameter int TAPS   = 3
) (
   input  logic [STAGES-1:0] stg,
   output logic [TAPS-1:0]   taps
);

   localparam int BASE = first_tap(STAGES, TAPS);

   generate
      for (genvar t = 0; t < TAPS; t++) begin : g_tap
         assign taps[t] = stg[BASE+t];
      end
   endgenerate

endmodule

// File: rtl/plso_shreg.sv
module plso_shreg #(
   parameter int STAGES     = 8,
   parameter int TAPS       = 3,
   parameter int LOAD_ASYNC = 0
) (
   input  logic              clk,
   input  logic              ser_in,
   input  logic              ld_sel,
   input  logic [STAGES-1:0] par_in,
   output logic [TAPS-1:0]   tap_out
);

   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2)                    begin : g_bad_len  $error("STAGES must be at least 2"); end
      if (TAPS < 2 || TAPS > STAGES)     begin : g_bad_taps $error("TAPS must lie in 2..STAGES"); end
      if (LOAD_ASYNC != 0 && LOAD_ASYNC != 1) begin : g_bad_mode $error("LOAD_ASYNC must be 0 or 1"); end
   endgenerate

   logic [STAGES-1:0] stg;
   logic [STAGES-1:0] feed;

   assign feed = {stg[LAST-1:0], ser_in};

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         plso_cell #(.LOAD_ASYNC(LOAD_ASYNC)) u_cell (
            .clk     (clk),
            .ld_sel  (ld_sel),
            .ser_bit (feed[k]),
            .par_bit (par_in[k]),
            .q       (stg[k])
         );
      end
   endgenerate

   plso_tap_buf #(.STAGES(STAGES), .TAPS(TAPS)) u_taps (
      .stg  (stg),
      .taps (tap_out)
   );

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   generate
      if (LOAD_ASYNC != 0) begin : g_chk_lvl
         // R4
         lvl_follow_chk: assert property (@(posedge clk) disable iff (!armed)
            ld_sel |-> (tap_out == par_in[LAST -: TAPS]));
      end else begin : g_chk_clk
         // R2
         tap_shift_chk: assert property (@(posedge clk) disable iff (!armed)
            !ld_sel |=> (tap_out[TAPS-1:1] == $past(tap_out[TAPS-2:0])));
      end
   endgenerate

endmodule

// File: tb/plso_shreg_test.sv
module plso_shreg_test;

   logic       clk = 1'b0;
   logic       ser = 1'b0;
   logic       sel_s = 1'b1;
   logic       sel_a = 1'b1;
   logic [7:0] par = 8'h00;
   logic [2:0] tap_s, tap_a, tap_t;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [7:0] ms, ma, mt;

   always #5 clk = ~clk;

   plso_shreg #(.LOAD_ASYNC(0)) uut (
      .clk(clk), .ser_in(ser), .ld_sel(sel_s), .par_in(par), .tap_out(tap_s));
   plso_shreg #(.LOAD_ASYNC(1)) uut_async (
      .clk(clk), .ser_in(ser), .ld_sel(sel_a), .par_in(par), .tap_out(tap_a));
   plso_shreg #(.LOAD_ASYNC(0)) uut_next (
      .clk(clk), .ser_in(tap_s[2]), .ld_sel(sel_s), .par_in(par), .tap_out(tap_t));

   function automatic logic [7:0] nxt(input logic [7:0] s, input logic ld,
                                      input logic si, input logic [7:0] p);
      return ld ? p : {s[6:0], si};
   endfunction

   function automatic logic [2:0] tp(input logic [7:0] s);
      return s[7:5];
   endfunction

   task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   // one rising edge; inputs were set before, models follow
   task automatic edge_step();
      logic [7:0] ps;
      @(posedge clk);
      #1;
      ps = ms;
      ms = nxt(ms, sel_s, ser, par);
      mt = nxt(mt, sel_s, ps[7], par);
      ma = nxt(ma, sel_a, ser, par);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      // R4: level load before any edge
      par = 8'hA5;
      #1;
      ma = 8'hA5;
      chk("R4 initial level load", tap_a, tp(ma));
      edge_step();
      // R1 R3: first clocked load gives the known start state
      chk("R1 R3 start state after load", tap_s, tp(8'hA5));
      chk("R9 tail start state", tap_t, tp(8'hA5));
      chk("R5 edge during level load", tap_a, tp(8'hA5));

      // R8: bus change between edges with select high
      par = 8'h1F;
      #2;
      chk("R8 no early capture", tap_s, tp(ms));
      chk("R4 level load follows bus", tap_a, tp(8'h1F));
      ma = 8'h1F;
      edge_step();
      chk("R3 capture on edge", tap_s, tp(8'h1F));

      // R7: select pulse between edges, then shift
      sel_s = 1'b0; sel_a = 1'b0; ser = 1'b1;
      par = 8'h00;
      edge_step();
      #1;
      sel_a = 1'b1; par = 8'hC0; #1; ma = 8'hC0;
      par = 8'h60; #1; ma = 8'h60;
      sel_a = 1'b0;
      #1;
      chk("R7 word held after release", tap_a, tp(8'h60));
      par = 8'hFF;
      #1;
      chk("R4 no load when released", tap_a, tp(8'h60));
      ser = 1'b0;
      edge_step();
      chk("R7 shift from loaded word", tap_a, tp(8'hC0));
      chk("R2 clocked shift", tap_s, tp(ms));

      // R6: falling edge and steady clock
      @(negedge clk);
      ser = 1'b1;
      #2;
      chk("R6 falling edge clocked", tap_s, tp(ms));
      chk("R6 falling edge level", tap_a, tp(ma));

      // R1 R2: a single one walks from stage 1 to stage 8
      sel_s = 1'b1; par = 8'h00; edge_step();
      sel_s = 1'b0; ser = 1'b1; edge_step();
      ser = 1'b0;
      for (int i = 2; i <= 8; i++) begin
         edge_step();
         if (i >= 6) chk("R1 R2 walking one", tap_s, 3'b001 << (i - 6));
      end

      // random mix, all three instances against the models
      for (int n = 0; n < 300; n++) begin
         sel_s = ($urandom % 4) == 0;
         sel_a = sel_s;
         ser = $urandom % 2;
         par = $urandom;
         if (sel_a) begin
            #1;
            ma = par;
            chk("R4 random level load", tap_a, tp(ma));
         end
         edge_step();
         chk(sel_s ? "R3 random clocked load" : "R2 random clocked shift", tap_s, tp(ms));
         chk(sel_a ? "R5 random level load" : "R2 random level shift", tap_a, tp(ma));
         chk("R9 random cascade", tap_t, tp(mt));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule